// File: doc/BRIEF.md
# Radix-2^2 Delay-Feedback Stage Pair

This block holds two consecutive stages of a streaming decimation-in-frequency FFT for one data path. One complex sample enters per accepted clock. A first butterfly pairs samples that lie N/4 apart and uses a feedback buffer of N/4 entries. A second butterfly pairs the resulting stream N/8 apart through its own buffer of N/8 entries, and it applies a trivial -j rotation by exchanging and negating parts, so it needs no multiplier. One complex sample leaves per accepted clock. The block is meant to be instantiated once for the even path and once for the odd path of a two-path transform. Each path therefore sees half the samples, and the clock runs at half the sample rate. A twiddle multiplier, which is outside this block, follows it.

One counter of log2(N/2) bits advances only on accepted samples and sets the phase of both stages. Its top bit chooses load or compute for the first butterfly. The next bit does the same for the second. A small sequencer follows the fill-up after reset through three states. SEQ_FILL1 lasts while the first buffer takes its first N/4 samples and moves to SEQ_FILL2 on the acceptance of sample N/4-1. SEQ_FILL2 lasts while the second buffer fills and moves to SEQ_RUN on the acceptance of sample N/4+N/8-1. SEQ_RUN holds until reset. Samples accepted in SEQ_RUN are tagged live, and only live samples raise the output valid. Each butterfly widens its sums by one bit plus a guard bit and then halves them with an arithmetic right shift, so every stage returns to the input width.

Top module: `r22_sdf_pair`

## Requirements
- R1: While reset is applied, and on the first clock after it is released, out_valid is 0 and out_re/out_im are 0. Both feedback buffers start out holding zeros.
- R2: Number the accepted samples j = 0, 1, 2 and so on from reset. When sample j is accepted at a clock edge, out_valid is 1 after the next edge if j >= N/4+N/8 (48 by default), and 0 otherwise. out_valid is 0 in every other cycle.
- R3: A cycle with in_valid low advances neither the counter nor any buffer, and out_re/out_im keep their values.
- R4: The intermediate stream u uses p = j mod (N/2). For p >= N/4, u[j] = floor((x[j-N/4] + x[j]) / 2). For p < N/4, u[j] = floor((x[j-N/2] - x[j-N/4]) / 2), and u[j] = 0 while j < N/2. This applies to the real and imaginary parts separately.
- R5: The output stream uses q = j mod (N/4). For q >= N/8, out[j] = floor((u[j-N/8] + v[j]) / 2). For q < N/8, out[j] = floor((u[j-N/4] - v[j-N/8]) / 2).
- R6: v[i] = u[i], except when i mod (N/2) lies in [N/8, N/4). In that case v[i] = -j*u[i], which means re(v) = im(u) and im(v) = -re(u).
- R7: Sums, differences and the negation in R6 are formed at full precision before the halving. Full-scale inputs of -512 and +511 never wrap, and the halving rounds toward minus infinity.
- R8: The counter wraps every N/2 accepted samples. R4 to R6 hold across any number of frames without a new reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept in_re/in_im at this edge |
| in_re | input | W | Input real part, two's complement |
| in_im | input | W | Input imaginary part, two's complement |
| out_valid | output | 1 | out_re/out_im carry a live result |
| out_re | output | W | Output real part |
| out_im | output | W | Output imaginary part |

## Verification
A counter that slips by even one sample swaps load and compute phases. The output then mixes pairs N/4 or N/8 apart wrongly, and this is visible from the first live output. A corrupted first-stage buffer entry reaches the port N/4 accepted samples later, or one frame later if it hits a stored difference. An error in the second stage appears within N/8 samples. A wrong rotation condition affects only the quarter-frame that carries the -j leg, so the bench compares every live output against a model of R4 to R6. It uses stimulus with a nonzero imaginary part so that a missing or misplaced swap cannot go unseen. Stall handling and fill-up errors show up at once as a moving output or a misplaced out_valid edge.

// File: rtl/r22_pkg.sv
package r22_pkg;

    localparam int DEF_N = 128;
    localparam int DEF_W = 10;

    typedef enum logic [1:0] {
        SEQ_FILL1,
        SEQ_FILL2,
        SEQ_RUN
    } seq_state_t;

endpackage

// File: rtl/r22_seq.sv
module r22_seq
    import r22_pkg::*;
#(
    parameter int N  = DEF_N,
    parameter int D1 = N / 4,
    parameter int D2 = N / 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    output logic [1:0] phase,
    output logic       live
);

    localparam int CW = $clog2(N / 2);
    localparam logic [CW-1:0] END1 = CW'(D1 - 1);
    localparam logic [CW-1:0] END2 = CW'(D1 + D2 - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;

    // shared free-running sample counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_FILL1;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_FILL1: if (adv && cnt_q == END1) state_d = SEQ_FILL2;
            SEQ_FILL2: if (adv && cnt_q == END2) state_d = SEQ_RUN;
            SEQ_RUN:   state_d = SEQ_RUN;
            default:   state_d = SEQ_FILL1;
        endcase
    end

    // outputs
    always_comb begin
        phase = cnt_q[CW-1 -: 2];
        unique case (state_q)
            SEQ_RUN: live = 1'b1;
            default: live = 1'b0;
        endcase
    end

endmodule

// File: rtl/r22_fbuf.sv
module r22_fbuf #(
    parameter int DEPTH = 32,
    parameter int BW    = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [BW-1:0] din,
    output logic [BW-1:0] dout
);

    logic [BW-1:0] tap [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tap[i] <= '0;
                end else if (en) begin
                    tap[i] <= din;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tap[i] <= '0;
                end else if (en) begin
                    tap[i] <= tap[i-1];
                end
            end
        end
    end

    assign dout = tap[DEPTH-1];

endmodule

// File: rtl/r22_bfly.sv
module r22_bfly #(
    parameter int W      = 10,
    parameter int DEPTH  = 32,
    parameter bit ROT_EN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         mode,
    input  logic         rot,
    input  logic [W-1:0] x_re,
    input  logic [W-1:0] x_im,
    output logic [W-1:0] y_re,
    output logic [W-1:0] y_im
);

    localparam int XW = W + 1;
    localparam int SW = W + 2;

    logic [2*W-1:0]       head, push;
    logic [W-1:0]         h_re, h_im;
    logic [XW-1:0]        xe_re, xe_im, lo_re, lo_im;
    logic                 do_rot;
    logic signed [SW-1:0] sum_re, sum_im, dif_re, dif_im;
    logic [W-1:0]         sh_sum_re, sh_sum_im, sh_dif_re, sh_dif_im;

    r22_fbuf #(.DEPTH(DEPTH), .BW(2*W)) u_fbuf (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .din  (push),
        .dout (head)
    );

    assign h_re   = head[2*W-1:W];
    assign h_im   = head[W-1:0];
    assign xe_re  = {x_re[W-1], x_re};
    assign xe_im  = {x_im[W-1], x_im};
    assign do_rot = ROT_EN & rot;

    // lower leg, multiplied by -j when requested: (re, im) -> (im, -re)
    assign lo_re = do_rot ? xe_im : xe_re;
    assign lo_im = do_rot ? (XW'(0) - xe_re) : xe_im;

    assign sum_re = $signed({{2{h_re[W-1]}}, h_re}) + $signed({lo_re[XW-1], lo_re});
    assign sum_im = $signed({{2{h_im[W-1]}}, h_im}) + $signed({lo_im[XW-1], lo_im});
    assign dif_re = $signed({{2{h_re[W-1]}}, h_re}) - $signed({lo_re[XW-1], lo_re});
    assign dif_im = $signed({{2{h_im[W-1]}}, h_im}) - $signed({lo_im[XW-1], lo_im});

    assign sh_sum_re = W'(sum_re >>> 1);
    assign sh_sum_im = W'(sum_im >>> 1);
    assign sh_dif_re = W'(dif_re >>> 1);
    assign sh_dif_im = W'(dif_im >>> 1);

    assign push = mode ? {sh_dif_re, sh_dif_im} : {x_re, x_im};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_re <= '0;
            y_im <= '0;
        end else if (en) begin
            y_re <= mode ? sh_sum_re : h_re;
            y_im <= mode ? sh_sum_im : h_im;
        end
    end

endmodule

// File: rtl/r22_sdf_pair.sv
module r22_sdf_pair
    import r22_pkg::*;
#(
    parameter int N = DEF_N,
    parameter int W = DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_re,
    input  logic [W-1:0] in_im,
    output logic         out_valid,
    output logic [W-1:0] out_re,
    output logic [W-1:0] out_im
);

    localparam int D1 = N / 4;
    localparam int D2 = N / 8;

    logic [1:0]   phase, s1_phase;
    logic         live, s1_live, s2_live;
    logic         s1_v, s2_v;
    logic [W-1:0] s1_re, s1_im;

    r22_seq #(.N(N), .D1(D1), .D2(D2)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (in_valid),
        .phase(phase),
        .live (live)
    );

    r22_bfly #(.W(W), .DEPTH(D1), .ROT_EN(1'b0)) u_bf1 (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (in_valid),
        .mode (phase[1]),
        .rot  (1'b0),
        .x_re (in_re),
        .x_im (in_im),
        .y_re (s1_re),
        .y_im (s1_im)
    );

    // tags travelling with the first-stage result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_phase <= '0;
            s1_live  <= 1'b0;
            s2_v     <= 1'b0;
            s2_live  <= 1'b0;
        end else begin
            s1_v <= in_valid;
            s2_v <= s1_v;
            if (in_valid) begin
                s1_phase <= phase;
                s1_live  <= live;
            end
            if (s1_v) begin
                s2_live <= s1_live;
            end
        end
    end

    // -j applies to the lower leg of blocks holding stage-one differences
    r22_bfly #(.W(W), .DEPTH(D2), .ROT_EN(1'b1)) u_bf2 (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (s1_v),
        .mode (s1_phase[0]),
        .rot  (~s1_phase[1] & s1_phase[0]),
        .x_re (s1_re),
        .x_im (s1_im),
        .y_re (out_re),
        .y_im (out_im)
    );

    assign out_valid = s2_v & s2_live;

endmodule

// File: rtl/r22_sdf_pair_chk.sv
module r22_sdf_pair_chk #(
    parameter int N = 128,
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] out_re,
    input logic [W-1:0] out_im
);

    localparam int WARM = N / 4 + N / 8;
    localparam int AW   = $clog2(WARM + 1);

    logic [AW-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (in_valid && acc != AW'(WARM)) begin
            acc <= acc + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && out_re == '0 && out_im == '0));

    // R2
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R2
    valid_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (acc == AW'(WARM)));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && acc == AW'(WARM), 2) |-> out_valid);

    // R3
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_valid, 2) |-> ($stable(out_re) && $stable(out_im)));

endmodule

bind r22_sdf_pair r22_sdf_pair_chk #(.N(N), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_re   (out_re),
    .out_im   (out_im)
);

// File: tb/test_r22_sdf_pair.sv
module test_r22_sdf_pair;

    localparam int W    = 10;
    localparam int MAXS = 400;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_re = '0;
    logic [W-1:0] in_im = '0;
    logic         out_valid;
    logic [W-1:0] out_re, out_im;

    int checks = 0;
    int errors = 0;
    int xr [MAXS];
    int xi [MAXS];

    bit     mon_on = 1'b0;
    bit     pv;
    int     pidx, acc;
    logic [W-1:0] hre, him;
    string  dtag = "R4";

    always #10 clk = ~clk;

    r22_sdf_pair i_r22_sdf_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_re    (in_re),
        .in_im    (in_im),
        .out_valid(out_valid),
        .out_re   (out_re),
        .out_im   (out_im)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // R4: first-stage model
    function automatic void s1v(input int j, output int re, output int im);
        int p = j % 64;
        if (p >= 32) begin
            re = (xr[j-32] + xr[j]) >>> 1;
            im = (xi[j-32] + xi[j]) >>> 1;
        end else if (j < 64) begin
            re = 0;
            im = 0;
        end else begin
            re = (xr[j-64] - xr[j-32]) >>> 1;
            im = (xi[j-64] - xi[j-32]) >>> 1;
        end
    endfunction

    // R6: rotated lower leg
    function automatic void vv(input int i, output int re, output int im);
        int ur, ui;
        s1v(i, ur, ui);
        if ((i % 64) >= 16 && (i % 64) < 32) begin
            re = ui;
            im = -ur;
        end else begin
            re = ur;
            im = ui;
        end
    endfunction

    // R5: second-stage model
    function automatic void s2v(input int j, output int re, output int im);
        int ar, ai, br, bi;
        if ((j % 32) >= 16) begin
            s1v(j - 16, ar, ai);
            vv(j, br, bi);
            re = (ar + br) >>> 1;
            im = (ai + bi) >>> 1;
        end else begin
            s1v(j - 32, ar, ai);
            vv(j - 16, br, bi);
            re = (ar - br) >>> 1;
            im = (ai - bi) >>> 1;
        end
    endfunction

    // monitor: samples well after each rising edge
    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            if (pv) begin
                if (pidx >= 48) begin
                    int er, ei;
                    s2v(pidx, er, ei);
                    chk(out_valid === 1'b1, "R2 valid", int'(out_valid), 1);
                    chk($signed(out_re) == er, {dtag, " re"}, $signed(out_re), er);
                    chk($signed(out_im) == ei, {dtag, " im"}, $signed(out_im), ei);
                end else begin
                    chk(out_valid === 1'b0, "R2 warm", int'(out_valid), 0);
                end
            end else begin
                chk(out_valid === 1'b0, "R3 idle valid", int'(out_valid), 0);
                chk(out_re == hre && out_im == him, "R3 hold", $signed(out_re), $signed(hre));
            end
            hre  = out_re;
            him  = out_im;
            pv   = in_valid;
            pidx = acc;
            if (in_valid) acc++;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        mon_on   = 1'b0;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pv    = 1'b0;
        pidx  = 0;
        acc   = 0;
        hre   = '0;
        him   = '0;
        mon_on = 1'b1;
    endtask

    task automatic fill(input int pat, input int n);
        for (int i = 0; i < n; i++) begin
            unique case (pat)
                0: begin xr[i] = (i * 37) % 1024 - 512; xi[i] = (i * 91 + 13) % 1024 - 512; end
                1: begin xr[i] = (i % 29 == 5) ? 300 : 0; xi[i] = (i % 23 == 7) ? -211 : 0; end
                2: begin xr[i] = 0; xi[i] = ((i * 53) % 700) - 350; end
                default: begin
                    xr[i] = ((i / 3) % 2 == 1) ? 511 : -512;
                    xi[i] = (i % 2 == 1) ? -512 : 511;
                end
            endcase
        end
    endtask

    task automatic drive(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re    = W'(xr[i]);
            in_im    = W'(xi[i]);
            if (gaps && (i % 7 == 3)) begin
                for (int g = 0; g <= i % 3; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 valid", int'(out_valid), 0);
        chk(out_re == '0, "R1 re", $signed(out_re), 0);
        chk(out_im == '0, "R1 im", $signed(out_im), 0);
    endtask

    task automatic t_ramp();
        dtag = "R4";
        fill(0, 256);
        do_reset();
        drive(256, 1'b0);
    endtask

    task automatic t_sparse();
        dtag = "R5";
        fill(1, 256);
        do_reset();
        drive(256, 1'b0);
    endtask

    task automatic t_rotation();
        dtag = "R6";
        fill(2, 256);
        do_reset();
        drive(256, 1'b0);
    endtask

    task automatic t_full_scale();
        dtag = "R7";
        fill(3, 256);
        do_reset();
        drive(256, 1'b0);
    endtask

    task automatic t_gapped_frames();
        dtag = "R8";
        fill(0, 384);
        for (int i = 0; i < 384; i++) xi[i] = ((i * 29) % 900) - 450;
        do_reset();
        drive(384, 1'b1);
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_reset();
        t_sparse();
        t_rotation();
        t_full_scale();
        t_gapped_frames();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule